// File: doc/BRIEF.md
# Prescaled Interval Timer with Auto-Reload

This block is a down-counting interval timer for a processor core. Software reaches four word-wide registers through a simple write strobe and a two-bit register index: control, period, scale and count. Once both the power bit and the run bit in control are set, a programmable prescaler slows the count. Each prescaled tick lowers the count by one.

When the count runs out, the timer latches a sticky flag in control and raises its interrupt output for one clock. With the reload bit set, it copies the period value back into the count and keeps going. With the reload bit clear, it leaves the count at zero and clears the run bit, so it stops.

Software reads the count at any time and always gets the current value. It may rewrite period or count while the timer runs. A period write also loads the count, so a single write arms the timer.

Top module: `core_tick_timer`

## Requirements
- R1: Register index 0 selects control, 1 period, 2 scale and 3 count (byte offsets 0x0, 0x4, 0x8, 0xC). After reset every register reads zero. Control bits above bit 3 always read zero.
- R2: The count changes only while control bit 0 (power) and bit 1 (run) are both set. If either is clear, the count holds its value.
- R3: The prescale divisor is scale[7:0]+1. Scale bits above bit 7 are stored and read back, but they do not change the tick rate.
- R4: A tick that finds the count at 1 or 0 is an expiry. It sets control bit 3 (flag), and irq_out is high for exactly the one cycle that follows the expiry edge.
- R5: At an expiry with control bit 2 (reload) set, the count takes the period value and counting continues.
- R6: At an expiry with reload clear, the count becomes 0 and control bit 1 is cleared, so counting stops.
- R7: A write to period stores the value in both period and count.
- R8: A control write stores bits 3:0 as written, so writing 0 to the flag clears it. A control write in the same cycle as an expiry overrides every control bit.
- R9: Period and count accept writes while the timer runs. A count or period write overrides a decrement or reload in the same cycle.
- R10: Reading count returns the register's present value in the same cycle, including while the timer runs.
- R11: The prescale phase is cleared by a scale write and while the timer is stopped. The k-th decrement after a control write that starts the timer happens (scale[7:0]+1)*k cycles after that write's edge. A scale write keeps the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Register write strobe |
| reg_idx | input | 2 | Register index (word offset) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data of the indexed register |
| irq_out | output | 1 | One-cycle interrupt pulse per expiry |

## Verification
Directed sequences check three behaviours in isolation:
- A divisor of four whose upper scale bits are set, which tells the real divisor apart from one that would use the whole register.
- A partial control value with only one of the power and run bits set, which tells a two-bit gate apart from a one-bit gate.
- A one-shot run and a reloading run with small periods, which tell the stop path from the reload path and pin the cycle of the interrupt pulse.

A long seeded random phase then mixes register writes of every kind, mostly with small periods and divisors. This makes expiries, same-cycle write collisions and mid-phase scale changes frequent. Every register read and the interrupt pin are compared each cycle with a cycle model in the bench.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

   // Word index of each register; the order fixes the byte offsets.
   typedef enum logic [1:0] {
      IDX_CTRL   = 2'd0,
      IDX_PERIOD = 2'd1,
      IDX_SCALE  = 2'd2,
      IDX_COUNT  = 2'd3
   } reg_idx_e;

   localparam int CTRL_BITS = 4;

   // Control field, bit 3 down to bit 0.
   typedef struct packed {
      logic flag;
      logic reload;
      logic enable;
      logic power;
   } ctrl_t;

endpackage

// File: rtl/ctmr_prescaler.sv
module ctmr_prescaler #(
   parameter int PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [PRE_W-1:0] divide_m1,
   output logic             tick
);

   logic [PRE_W-1:0] phase_q;

   assign tick = run && (phase_q == divide_m1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (restart || !run || tick) begin
         phase_q <= '0;
      end else begin
         phase_q <= phase_q + PRE_W'(1);
      end
   end

   // R3: the phase never runs past the divisor limit
   p_phase_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      phase_q <= divide_m1);

   // R11: with a divisor above one, ticks are never back to back
   p_tick_spacing_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && divide_m1 != '0 && !restart) |=> !tick);

endmodule

// File: rtl/ctmr_counter.sv
module ctmr_counter #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              load,
   input  logic [DATA_W-1:0] load_val,
   input  logic              reload,
   input  logic [DATA_W-1:0] period,
   output logic [DATA_W-1:0] count,
   output logic              expire
);

   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   assign expire = tick && (count <= ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (load) begin
         count <= load_val;
      end else if (expire) begin
         count <= reload ? period : '0;
      end else if (tick) begin
         count <= count - ONE;
      end
   end

   // R11: an ordinary tick lowers the count by exactly one
   p_decrement_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && count > ONE && !load) |=> count == $past(count) - ONE);

   // R5: expiry with reload copies the period
   p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && reload && !load) |=> count == $past(period));

   // R6: expiry without reload parks at zero
   p_park_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !reload && !load) |=> count == '0);

   // R9: a software load wins over any tick
   p_load_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> count == $past(load_val));

endmodule

// File: rtl/ctmr_regs.sv
module ctmr_regs
   import ctmr_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int PRE_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        idx,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] count,
   input  logic              expire,
   output logic [DATA_W-1:0] rdata,
   output logic              run,
   output logic              reload,
   output logic [DATA_W-1:0] period,
   output logic [PRE_W-1:0]  divide_m1,
   output logic              pre_restart,
   output logic              cnt_load,
   output logic [DATA_W-1:0] cnt_load_val
);

   reg_idx_e          sel;
   ctrl_t             ctrl_q;
   logic [DATA_W-1:0] period_q;
   logic [DATA_W-1:0] scale_q;
   logic [DATA_W-1:0] ctrl_rd;
   logic              wr_ctrl, wr_period, wr_scale, wr_count;

   assign sel       = reg_idx_e'(idx);
   assign wr_ctrl   = wr_en && (sel == IDX_CTRL);
   assign wr_period = wr_en && (sel == IDX_PERIOD);
   assign wr_scale  = wr_en && (sel == IDX_SCALE);
   assign wr_count  = wr_en && (sel == IDX_COUNT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         period_q <= '0;
         scale_q  <= '0;
      end else begin
         if (wr_ctrl) begin
            ctrl_q <= ctrl_t'(wdata[CTRL_BITS-1:0]);
         end else if (expire) begin
            ctrl_q.flag <= 1'b1;
            if (!ctrl_q.reload) begin
               ctrl_q.enable <= 1'b0;
            end
         end
         if (wr_period) begin
            period_q <= wdata;
         end
         if (wr_scale) begin
            scale_q <= wdata;
         end
      end
   end

   assign run          = ctrl_q.power && ctrl_q.enable;
   assign reload       = ctrl_q.reload;
   assign period       = period_q;
   assign divide_m1    = scale_q[PRE_W-1:0];
   assign pre_restart  = wr_scale;
   assign cnt_load     = wr_period || wr_count;
   assign cnt_load_val = wdata;

   generate
      if (DATA_W > CTRL_BITS) begin : g_ctrl_pad
         assign ctrl_rd = {{(DATA_W-CTRL_BITS){1'b0}}, ctrl_q};
      end else begin : g_ctrl_exact
         assign ctrl_rd = ctrl_q;
      end
   endgenerate

   always_comb begin
      unique case (sel)
         IDX_CTRL:   rdata = ctrl_rd;
         IDX_PERIOD: rdata = period_q;
         IDX_SCALE:  rdata = scale_q;
         IDX_COUNT:  rdata = count;
         default:    rdata = '0;
      endcase
   end

   // R4: an expiry without a competing control write latches the flag
   p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !wr_ctrl) |=> ctrl_q.flag);

   // R6: a one-shot expiry drops the run bit
   p_oneshot_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !ctrl_q.reload && !wr_ctrl) |=> !ctrl_q.enable);

   // R8: control bits take the written value, expiry or not
   p_ctrl_direct_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> ctrl_q == $past(wdata[CTRL_BITS-1:0]));

endmodule

// File: rtl/core_tick_timer.sv
module core_tick_timer
   import ctmr_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int PRE_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr_en,
   input  logic [1:0]        reg_idx,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_out
);

   initial begin
      assert (DATA_W >= 8) else $error("DATA_W must be at least 8");
      assert (PRE_W >= 1 && PRE_W <= DATA_W) else $error("PRE_W out of range");
   end

   logic              run, reload, pre_restart, cnt_load, tick, expire, irq_q;
   logic [DATA_W-1:0] period, count, cnt_load_val;
   logic [PRE_W-1:0]  divide_m1;

   ctmr_regs #(.DATA_W(DATA_W), .PRE_W(PRE_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .idx(reg_idx),
      .wdata(bus_wdata), .count(count), .expire(expire), .rdata(bus_rdata),
      .run(run), .reload(reload), .period(period), .divide_m1(divide_m1),
      .pre_restart(pre_restart), .cnt_load(cnt_load), .cnt_load_val(cnt_load_val)
   );

   ctmr_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(run), .restart(pre_restart),
      .divide_m1(divide_m1), .tick(tick)
   );

   ctmr_counter #(.DATA_W(DATA_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .load(cnt_load),
      .load_val(cnt_load_val), .reload(reload), .period(period),
      .count(count), .expire(expire)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
      end else begin
         irq_q <= expire;
      end
   end

   assign irq_out = irq_q;

   // R2: a stopped timer holds its count unless software loads it
   p_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !cnt_load) |=> $stable(count));

   // R10: the count index returns the live counter value
   p_live_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_idx == IDX_COUNT) |-> bus_rdata == count);

   // R4: the interrupt is only raised while running or just after
   p_irq_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> $past(run));

endmodule

// File: tb/test_core_tick_timer.sv
module test_core_tick_timer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  idx = 2'd0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   core_tick_timer #(.DATA_W(32), .PRE_W(8)) i_core_tick_timer (
      .clk(clk), .rst_n(rst_n), .bus_wr_en(wr_en), .reg_idx(idx),
      .bus_wdata(wdata), .bus_rdata(rdata), .irq_out(irq)
   );

   // Cycle model built from the requirements.
   logic [3:0]  m_ctl = '0;
   logic [31:0] m_per = '0, m_scl = '0, m_cnt = '0;
   logic [7:0]  m_pre = '0;
   logic        m_irq = 1'b0;

   always @(posedge clk) begin : model
      logic run, tk, ex;
      if (!rst_n) begin
         m_ctl = '0; m_per = '0; m_scl = '0; m_cnt = '0; m_pre = '0; m_irq = 1'b0;
      end else begin
         run = m_ctl[0] & m_ctl[1];
         tk  = run && (m_pre == m_scl[7:0]);
         ex  = tk && (m_cnt <= 32'd1);
         if (wr_en && idx == 2'd2) m_pre = '0;
         else if (!run || tk)      m_pre = '0;
         else                      m_pre = m_pre + 8'd1;
         if (wr_en && (idx == 2'd1 || idx == 2'd3)) m_cnt = wdata;
         else if (ex)                               m_cnt = m_ctl[2] ? m_per : 32'd0;
         else if (tk)                               m_cnt = m_cnt - 32'd1;
         if (wr_en && idx == 2'd0) m_ctl = wdata[3:0];
         else if (ex) begin
            m_ctl[3] = 1'b1;
            if (!m_ctl[2]) m_ctl[1] = 1'b0;
         end
         if (wr_en && idx == 2'd1) m_per = wdata;
         if (wr_en && idx == 2'd2) m_scl = wdata;
         m_irq = ex;
      end
   end

   function automatic logic [31:0] model_read(input logic [1:0] i);
      case (i)
         2'd0:    return {28'd0, m_ctl};
         2'd1:    return m_per;
         2'd2:    return m_scl;
         default: return m_cnt;
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] i, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; idx = i; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rdchk(input logic [1:0] i, input logic [31:0] exp, input string req);
      idx = i;
      #1;
      chk(req, rdata, exp);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [31:0] gen_data(input logic [1:0] i);
      logic [31:0] d;
      d = $urandom;
      case (i)
         2'd0: if ($urandom % 4 != 0) d[1:0] = 2'b11;
         2'd2: d = (d & 32'hFFFF_FF00) | ($urandom % 4);
         default: d = $urandom % 24;
      endcase
      return d;
   endfunction

   initial begin : watchdog
      #(20 * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'd20240611));
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1: reset values
      for (int i = 0; i < 4; i++) rdchk(2'(i), 32'd0, "R1");

      // R7: period write arms count
      wr(2'd1, 32'd5);
      rdchk(2'd3, 32'd5, "R7");
      rdchk(2'd1, 32'd5, "R7");

      // R3 / R11: divisor 4 with upper scale bits set
      wr(2'd2, 32'h0000_0103);
      wr(2'd0, 32'h3);
      idle(4);
      rdchk(2'd3, 32'd4, "R11");
      idle(3);
      rdchk(2'd3, 32'd4, "R3");
      idle(1);
      rdchk(2'd3, 32'd3, "R11");
      rdchk(2'd2, 32'h0000_0103, "R3");

      // R2: run without power, then power without run
      wr(2'd0, 32'h2);
      idle(20);
      rdchk(2'd3, 32'd3, "R2");
      wr(2'd0, 32'h1);
      idle(10);
      rdchk(2'd3, 32'd3, "R2");

      // R9 / R10: writes and live reads while running
      wr(2'd3, 32'd100);
      rdchk(2'd3, 32'd100, "R9");
      wr(2'd2, 32'd0);
      wr(2'd0, 32'h3);
      idle(10);
      rdchk(2'd3, 32'd90, "R10");
      wr(2'd3, 32'd50);
      rdchk(2'd3, 32'd50, "R9");
      idle(2);
      rdchk(2'd3, 32'd48, "R10");

      // R4 / R6: one-shot expiry
      wr(2'd0, 32'h0);
      wr(2'd1, 32'd3);
      wr(2'd0, 32'h3);
      idle(2);
      chk("R4", {31'd0, irq}, 32'd0);
      rdchk(2'd3, 32'd1, "R11");
      idle(1);
      chk("R4", {31'd0, irq}, 32'd1);
      rdchk(2'd3, 32'd0, "R6");
      rdchk(2'd0, 32'h9, "R6");
      idle(1);
      chk("R4", {31'd0, irq}, 32'd0);
      idle(6);
      rdchk(2'd3, 32'd0, "R6");
      chk("R6", {31'd0, irq}, 32'd0);

      // R8 / R1: flag written directly, unused bits read zero
      wr(2'd0, 32'h1);
      rdchk(2'd0, 32'h1, "R8");
      wr(2'd0, 32'h8);
      rdchk(2'd0, 32'h8, "R8");
      wr(2'd0, 32'hFFFF_FFF0);
      rdchk(2'd0, 32'h0, "R1");

      // R5: auto-reload, divisor 2, period 2
      wr(2'd2, 32'd1);
      wr(2'd1, 32'd2);
      wr(2'd0, 32'h7);
      idle(4);
      chk("R4", {31'd0, irq}, 32'd1);
      rdchk(2'd3, 32'd2, "R5");
      rdchk(2'd0, 32'hF, "R5");
      idle(1);
      chk("R4", {31'd0, irq}, 32'd0);
      idle(1);
      rdchk(2'd3, 32'd1, "R5");
      idle(2);
      rdchk(2'd3, 32'd2, "R5");
      chk("R5", {31'd0, irq}, 32'd1);

      // Random phase against the cycle model (R8 priority, R10 live read)
      for (int n = 0; n < 3000; n++) begin
         logic [1:0] ri;
         @(negedge clk);
         wr_en = 1'b0;
         ri = 2'($urandom % 4);
         idx = ri;
         #1;
         case (ri)
            2'd0:    chk("R8",  rdata, model_read(ri));
            2'd1:    chk("R7",  rdata, model_read(ri));
            2'd2:    chk("R3",  rdata, model_read(ri));
            default: chk("R10", rdata, model_read(ri));
         endcase
         chk("R4", {31'd0, irq}, {31'd0, m_irq});
         if ($urandom % 4 == 0) begin
            ri = 2'($urandom % 4);
            wr_en = 1'b1;
            idx = ri;
            wdata = gen_data(ri);
         end
      end
      @(negedge clk);
      wr_en = 1'b0;

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule